// File: doc/BRIEF.md
# Macroblock Motion Vector Bank

The bank records one motion vector per 16x16 macroblock of a video frame and keeps the vector planes of several recent frames. A motion-estimation stage sends the vectors through a valid/ready stream. A start-of-frame flag marks the first macroblock, and the macroblocks that follow arrive in processing order. Each frame fills one slot of a circular set of slots. When the final macroblock of the frame lands, the bank pulses a completion strobe that names the slot. From then on that plane can be read as a unit until the rotation wraps and the slot is reused.

There are two independent read ports, and each has one cycle of latency. The analysis port takes a slot index and a macroblock address. It returns the stored vector and a one-bit motion flag, which is set only for a non-zero vector. A trajectory processor uses this flag to separate moving macroblocks from the background. The feedback port takes only an address. It always reads the most recently completed plane, so the estimator can use last frame's vectors as predictors.

Top module: `mvec_bank`

## Requirements
- R1: An accepted beat with wr_sof high writes macroblock address 0 of the current write slot. Each later accepted beat writes the next address, from 1 up to MB_COLS*MB_ROWS-1.
- R2: An accepted beat with wr_sof low that arrives while no frame is open is dropped. It writes nothing and produces no completion.
- R3: One cycle after the beat at the last address is accepted, frame_ready is high for exactly one cycle. No completion strobe appears at any other time.
- R4: Frames occupy slots 0, 1, …, SLOTS-1 and then wrap to 0, overwriting the oldest plane. frame_slot carries the index of the slot that has just completed while frame_ready is high.
- R5: An accepted wr_sof while a frame is still open sets seq_err. seq_err stays set until reset. The write restarts at address 0 of the same slot, and the aborted frame gives no completion.
- R6: An analysis read issued in one cycle returns ana_rvalid and the stored vector {ana_mvy, ana_mvx} in the next cycle. A slot index ≥ SLOTS or an address ≥ MB_COLS*MB_ROWS returns a zero vector with ana_moving low.
- R7: ana_moving is 1 exactly when the returned vector has a non-zero x or y component.
- R8: A feedback read returns fb_rvalid and the vector at the given address of the most recently completed slot one cycle later. Before any frame has completed, the returned vector is zero.
- R9: A read from the slot being written returns the entries already written. A read of the entry that is being written in the same cycle returns its previous content.
- R10: While reset is active, wr_ready, frame_ready, seq_err, ana_rvalid and fb_rvalid are all low. From the first clock after reset, wr_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Vector beat valid |
| wr_ready | output | 1 | Bank accepts beats |
| wr_sof | input | 1 | Beat is the first macroblock of a frame |
| wr_mvx | input | CW | Horizontal vector component, two's complement |
| wr_mvy | input | CW | Vertical vector component, two's complement |
| frame_ready | output | 1 | One-cycle strobe: a plane has completed |
| frame_slot | output | SW | Slot of the completed plane |
| seq_err | output | 1 | Sticky: frame restarted before it was complete |
| ana_rd_en | input | 1 | Analysis read request |
| ana_slot | input | SW | Analysis read slot |
| ana_addr | input | AW | Analysis read macroblock address |
| ana_rvalid | output | 1 | Analysis read data valid |
| ana_mvx | output | CW | Analysis read x component |
| ana_mvy | output | CW | Analysis read y component |
| ana_moving | output | 1 | Macroblock has a non-zero vector |
| fb_rd_en | input | 1 | Feedback read request |
| fb_addr | input | AW | Feedback read macroblock address |
| fb_rvalid | output | 1 | Feedback read data valid |
| fb_mvx | output | CW | Feedback read x component |
| fb_mvy | output | CW | Feedback read y component |

## Verification
The assertions take three things for granted. MB_COLS*MB_ROWS is at least 2, so two completions can never be back to back. The read-enable inputs are known values in every cycle after reset. SLOTS is at least 2, so the slot-rotation check has a successor to test against. The bench keeps to these limits with a 3x2 frame and three slots. Its inputs are always driven to defined values. Beats are sent with idle gaps, before any frame is open, and as a restart in the middle of a frame, and each of these cases follows a path the assertions cover.

// File: rtl/mvec_bank.sv
module mvec_bank #(
  parameter int MB_COLS = 45,
  parameter int MB_ROWS = 30,
  parameter int SLOTS   = 4,
  parameter int CW      = 8,
  localparam int MBS    = MB_COLS * MB_ROWS,
  localparam int AW     = $clog2(MBS),
  localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_sof,
  input  logic [CW-1:0] wr_mvx,
  input  logic [CW-1:0] wr_mvy,
  output logic          frame_ready,
  output logic [SW-1:0] frame_slot,
  output logic          seq_err,
  input  logic          ana_rd_en,
  input  logic [SW-1:0] ana_slot,
  input  logic [AW-1:0] ana_addr,
  output logic          ana_rvalid,
  output logic [CW-1:0] ana_mvx,
  output logic [CW-1:0] ana_mvy,
  output logic          ana_moving,
  input  logic          fb_rd_en,
  input  logic [AW-1:0] fb_addr,
  output logic          fb_rvalid,
  output logic [CW-1:0] fb_mvx,
  output logic [CW-1:0] fb_mvy
);
  localparam int DEPTH = SLOTS * MBS;
  localparam int IW    = $clog2(DEPTH);

  logic [2*CW-1:0] vec_mem [DEPTH];
  logic            mot_mem [DEPTH];

  logic          in_frame;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_slot;
  logic [SW-1:0] done_slot;
  logic          have_done;

  wire           accept    = wr_valid & wr_ready;
  wire           put_en    = accept & (wr_sof | in_frame);
  wire [AW-1:0]  put_addr  = wr_sof ? '0 : wr_addr;
  wire           last_beat = put_en & (put_addr == AW'(MBS - 1));
  wire [SW-1:0]  slot_next = (wr_slot == SW'(SLOTS - 1)) ? '0 : wr_slot + 1'b1;
  wire [IW-1:0]  put_idx   = IW'(wr_slot) * IW'(MBS) + IW'(put_addr);

  wire           ana_ok  = (int'(ana_slot) < SLOTS) && (int'(ana_addr) < MBS);
  wire [IW-1:0]  ana_idx = IW'(ana_slot) * IW'(MBS) + IW'(ana_addr);
  wire           fb_ok   = have_done && (int'(fb_addr) < MBS);
  wire [IW-1:0]  fb_idx  = IW'(done_slot) * IW'(MBS) + IW'(fb_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ready    <= 1'b0;
      in_frame    <= 1'b0;
      wr_addr     <= '0;
      wr_slot     <= '0;
      done_slot   <= '0;
      have_done   <= 1'b0;
      frame_ready <= 1'b0;
      frame_slot  <= '0;
      seq_err     <= 1'b0;
    end else begin
      wr_ready    <= 1'b1;
      frame_ready <= 1'b0;
      if (accept & wr_sof & in_frame) seq_err <= 1'b1;
      if (put_en) begin
        if (last_beat) begin
          in_frame    <= 1'b0;
          wr_addr     <= '0;
          frame_ready <= 1'b1;
          frame_slot  <= wr_slot;
          done_slot   <= wr_slot;
          have_done   <= 1'b1;
          wr_slot     <= slot_next;
        end else begin
          in_frame <= 1'b1;
          wr_addr  <= put_addr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (put_en) begin
      vec_mem[put_idx] <= {wr_mvy, wr_mvx};
      mot_mem[put_idx] <= (wr_mvx != '0) || (wr_mvy != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (ana_rd_en) begin
      {ana_mvy, ana_mvx} <= ana_ok ? vec_mem[ana_idx] : '0;
      ana_moving         <= ana_ok ? mot_mem[ana_idx] : 1'b0;
    end
    if (fb_rd_en) {fb_mvy, fb_mvx} <= fb_ok ? vec_mem[fb_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ana_rvalid <= 1'b0;
      fb_rvalid  <= 1'b0;
    end else begin
      ana_rvalid <= ana_rd_en;
      fb_rvalid  <= fb_rd_en;
    end
  end
endmodule

// File: rtl/mvec_bank_chk.sv
module mvec_bank_chk #(
  parameter int SLOTS = 4,
  parameter int CW    = 8,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_sof,
  input logic          frame_ready,
  input logic [SW-1:0] frame_slot,
  input logic          seq_err,
  input logic          ana_rd_en,
  input logic          ana_rvalid,
  input logic [CW-1:0] ana_mvx,
  input logic [CW-1:0] ana_mvy,
  input logic          ana_moving,
  input logic          fb_rd_en,
  input logic          fb_rvalid
);
  logic          seen;
  logic [SW-1:0] prev_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      prev_slot <= '0;
    end else if (frame_ready) begin
      seen      <= 1'b1;
      prev_slot <= frame_slot;
    end
  end

  // R3
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> !frame_ready);
  // R3
  frame_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> $past(wr_valid && wr_ready));
  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (int'(frame_slot) < SLOTS));
  // R4
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && seen) |-> (int'(frame_slot) == ((int'(prev_slot) + 1) % SLOTS)));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> $past(wr_valid && wr_ready && wr_sof));
  // R6
  ana_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ana_rd_en |=> ana_rvalid);
  // R6
  ana_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_rd_en |=> !ana_rvalid);
  // R7
  moving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ana_rvalid |-> (ana_moving == ((ana_mvx != '0) || (ana_mvy != '0))));
  // R8
  fb_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |=> fb_rvalid);
  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready);
endmodule

bind mvec_bank mvec_bank_chk #(.SLOTS(SLOTS), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_sof(wr_sof), .frame_ready(frame_ready), .frame_slot(frame_slot),
  .seq_err(seq_err), .ana_rd_en(ana_rd_en), .ana_rvalid(ana_rvalid),
  .ana_mvx(ana_mvx), .ana_mvy(ana_mvy), .ana_moving(ana_moving),
  .fb_rd_en(fb_rd_en), .fb_rvalid(fb_rvalid)
);

// File: tb/mvec_bank_tb_top.sv
module mvec_bank_tb_top;
  localparam int COLS  = 3;
  localparam int ROWS  = 2;
  localparam int SLOTS = 3;
  localparam int MBS   = COLS * ROWS;
  localparam int AW    = $clog2(MBS);
  localparam int SW    = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic wr_valid = 0, wr_sof = 0, ana_rd_en = 0, fb_rd_en = 0;
  logic [7:0] wr_mvx = 0, wr_mvy = 0;
  logic [SW-1:0] ana_slot = 0;
  logic [AW-1:0] ana_addr = 0, fb_addr = 0;
  logic wr_ready, frame_ready, seq_err, ana_rvalid, ana_moving, fb_rvalid;
  logic [SW-1:0] frame_slot;
  logic [7:0] ana_mvx, ana_mvy, fb_mvx, fb_mvy;

  mvec_bank #(.MB_COLS(COLS), .MB_ROWS(ROWS), .SLOTS(SLOTS), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sof(wr_sof), .wr_mvx(wr_mvx), .wr_mvy(wr_mvy),
    .frame_ready(frame_ready), .frame_slot(frame_slot), .seq_err(seq_err),
    .ana_rd_en(ana_rd_en), .ana_slot(ana_slot), .ana_addr(ana_addr),
    .ana_rvalid(ana_rvalid), .ana_mvx(ana_mvx), .ana_mvy(ana_mvy),
    .ana_moving(ana_moving), .fb_rd_en(fb_rd_en), .fb_addr(fb_addr),
    .fb_rvalid(fb_rvalid), .fb_mvx(fb_mvx), .fb_mvy(fb_mvy));

  int checks = 0, errors = 0;
  string cur_tag = "R6";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int  mmem [SLOTS][MBS];
  bit  mk   [SLOTS][MBS];
  bit  m_rdy, m_inf, m_err, m_hp, live;
  int  m_addr, m_slot, m_last;
  bit  e_fr, e_av, e_ak, e_fv, e_fk;
  int  e_fs, e_ad, e_fd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rdy = 0; m_inf = 0; m_err = 0; m_hp = 0;
      m_addr = 0; m_slot = 0; m_last = 0;
      e_fr = 0; e_av = 0; e_fv = 0; e_ak = 0; e_fk = 0;
      foreach (mk[s, a]) mk[s][a] = 0;
    end else begin
      e_av = ana_rd_en;
      if (int'(ana_slot) < SLOTS && int'(ana_addr) < MBS) begin
        e_ak = mk[ana_slot][ana_addr]; e_ad = mmem[ana_slot][ana_addr];
      end else begin
        e_ak = 1; e_ad = 0;
      end
      e_fv = fb_rd_en;
      if (m_hp && int'(fb_addr) < MBS) begin
        e_fk = mk[m_last][fb_addr]; e_fd = mmem[m_last][fb_addr];
      end else begin
        e_fk = 1; e_fd = 0;
      end
      e_fr = 0;
      if (wr_valid && m_rdy && (wr_sof || m_inf)) begin
        if (wr_sof) begin
          if (m_inf) m_err = 1;
          m_addr = 0;
        end
        mmem[m_slot][m_addr] = int'({wr_mvy, wr_mvx});
        mk[m_slot][m_addr] = 1;
        if (m_addr == MBS - 1) begin
          e_fr = 1; e_fs = m_slot; m_last = m_slot; m_hp = 1;
          m_slot = (m_slot + 1) % SLOTS; m_inf = 0; m_addr = 0;
        end else begin
          m_addr++; m_inf = 1;
        end
      end
      m_rdy = 1;
    end
    live = 1;
  end

  always @(negedge clk) begin
    if (live) begin
      chk(wr_ready == m_rdy, "R10", wr_ready, m_rdy);
      chk(frame_ready == e_fr, "R3", frame_ready, e_fr);
      if (e_fr) chk(int'(frame_slot) == e_fs, "R4", frame_slot, e_fs);
      chk(seq_err == m_err, "R5", seq_err, m_err);
      chk(ana_rvalid == e_av, "R6", ana_rvalid, e_av);
      if (e_av && e_ak) begin
        chk(int'({ana_mvy, ana_mvx}) == e_ad, cur_tag, {ana_mvy, ana_mvx}, e_ad);
        chk(ana_moving == (e_ad != 0), "R7", ana_moving, e_ad != 0);
      end
      chk(fb_rvalid == e_fv, "R8", fb_rvalid, e_fv);
      if (e_fv && e_fk) chk(int'({fb_mvy, fb_mvx}) == e_fd, "R8", {fb_mvy, fb_mvx}, e_fd);
    end
  end

  function automatic logic [15:0] vec(input int f, input int a);
    int xi, yi;
    xi = (a == 2 || a == 5) ? 0 : (((a % 2) != 0) ? -(f * 7 + a + 1) : (f * 7 + a + 1));
    yi = (a == 2 || a == 4) ? 0 : (f * 3 - a);
    return {yi[7:0], xi[7:0]};
  endfunction

  task automatic step(input bit wv, input bit sof, input logic [15:0] v,
                      input bit ar, input int as, input int aa,
                      input bit fr, input int fa);
    @(negedge clk);
    wr_valid = wv; wr_sof = sof; {wr_mvy, wr_mvx} = v;
    ana_rd_en = ar; ana_slot = SW'(as); ana_addr = AW'(aa);
    fb_rd_en = fr; fb_addr = AW'(fa);
  endtask

  task automatic idle();
    step(0, 0, 16'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic frame(input int f, input int gap);
    for (int a = 0; a < MBS; a++) begin
      step(1, a == 0, vec(f, a), 0, 0, 0, 0, 0);
      if (gap != 0 && a % gap == 1) idle();
    end
  endtask

  task automatic read_slot(input int s);
    for (int a = 0; a < MBS; a++) step(0, 0, 16'h0, 1, s, a, 1, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs in reset
    chk(wr_ready == 0, "R10", wr_ready, 0);
    chk(frame_ready == 0, "R10", frame_ready, 0);
    chk(seq_err == 0, "R10", seq_err, 0);
    chk(ana_rvalid == 0, "R10", ana_rvalid, 0);
    chk(fb_rvalid == 0, "R10", fb_rvalid, 0);
    rst_n = 1;
    idle();
    // R8: feedback read before any completed frame gives zero
    step(0, 0, 16'h0, 0, 0, 0, 1, 0);
    // R2: beats without an open frame are dropped
    step(1, 0, 16'hAAAA, 0, 0, 0, 0, 0);
    step(1, 0, 16'h5555, 0, 0, 0, 0, 0);
    idle();
    cur_tag = "R1";
    frame(0, 3);
    idle();
    read_slot(0);
    // R9: read slot 1 while it fills, one address behind
    cur_tag = "R9";
    for (int a = 0; a < MBS; a++)
      step(1, a == 0, vec(1, a), a > 0, 1, a > 0 ? a - 1 : 0, 1, a);
    idle();
    cur_tag = "R1";
    read_slot(1);
    // R5: restart inside frame 2
    for (int a = 0; a < 3; a++) step(1, a == 0, vec(2, a), 0, 0, 0, 0, 0);
    frame(5, 0);
    idle();
    read_slot(2);
    // R4 wrap into slot 0, R9 same-cycle read returns old content
    cur_tag = "R9";
    for (int a = 0; a < MBS; a++) step(1, a == 0, vec(3, a), 1, 0, a, 0, 0);
    idle();
    cur_tag = "R4";
    read_slot(0);
    // R6 out-of-range reads
    cur_tag = "R6";
    step(0, 0, 16'h0, 1, 3, 0, 1, 7);
    step(0, 0, 16'h0, 1, 0, 6, 0, 0);
    step(0, 0, 16'h0, 1, 1, 7, 1, 6);
    idle();
    cur_tag = "R4";
    frame(4, 2);
    idle();
    read_slot(1);
    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule